// File: doc/BRIEF.md
# External Interrupt Pin Glitch Filter and Detector

This block conditions nine asynchronous interrupt input pins: eight maskable request pins and one non-maskable pin. Each raw pin passes through a two-flop synchronizer. A per-pin glitch filter follows. When enabled, it samples the synchronized level at a rate picked from four ratios of the peripheral clock. It moves its output to a new level only once three consecutive samples agree on that level. A pin whose filter is off forwards its synchronized level directly.

After the filter, each maskable pin has a detector with a 2-bit mode field. The field selects a level request, a falling-edge pulse, a rising-edge pulse, or a pulse on either edge. Requests that are routed to a DMA engine or a transfer controller must use one of the edge modes. The non-maskable pin always works on edges, and a single sense bit selects which edge. The outputs feed the interrupt flag logic of the surrounding controller.

Every pin of the block is a plain level or pulse signal. No stream interface exists, so there is no valid/ready handshake and no back-pressure. A request pulse that the downstream flag logic does not capture in its cycle is lost.

Top module: `eint_pin_filter`

## Requirements
- R1: While reset is held and after it is released, every filtered level is 1 (the idle level of the pins). No request is asserted in any edge mode, and no request is asserted in level mode while the pins stay high.
- R2: With a pin's filter disabled, its filtered level equals the raw pin delayed by exactly three clocks: two synchronizer flops and one output register.
- R3: With a pin's filter enabled, the filtered level changes only on a sampling tick. It takes the sampled value only when the current sample and the two samples before it are equal. A pulse that spans fewer than three samples therefore never reaches the output.
- R4: The 2-bit sample-rate code sets the filter sampling period: 00 samples every clock, 01 every 8th clock, 10 every 32nd clock and 11 every 64th clock. The per-pin rate counter restarts when the filter is enabled or the code changes. The first sample is then taken one full period later.
- R5: While a filter is disabled, its sample history tracks the input. Enabling the filter therefore never moves the filtered level and never produces a request by itself.
- R6: Mode code 00 (level, active low): the request is high exactly while the filtered level is 0.
- R7: Mode code 01 (falling edge): the request is high for the one clock in which the filtered level is 0 and was 1 one clock earlier.
- R8: Mode code 10 (rising edge): the request is high for the one clock in which the filtered level is 1 and was 0 one clock earlier.
- R9: Mode code 11 (both edges): the request is high for each clock in which the filtered level differs from its value one clock earlier.
- R10: The non-maskable pin has its own filter enable and rate code. Its detector uses a sense bit: 1 gives rising-edge behaviour as in R8, and 0 gives falling-edge behaviour as in R7.
- R11: The pins are independent. The configuration or activity of one pin never changes the level or request of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; also the filter sampling base |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 8 | Raw maskable interrupt pins |
| irq_flt_en | input | 8 | Per-pin filter enable |
| irq_clk_sel | input | 16 | Per-pin 2-bit sample-rate code, pin k at bits 2k+1:2k |
| irq_mode | input | 16 | Per-pin 2-bit detection mode, pin k at bits 2k+1:2k |
| nmi_pin | input | 1 | Raw non-maskable interrupt pin |
| nmi_flt_en | input | 1 | Filter enable of the non-maskable pin |
| nmi_clk_sel | input | 2 | Sample-rate code of the non-maskable pin |
| nmi_rise_sense | input | 1 | 1 selects the rising edge, 0 the falling edge |
| irq_level | output | 8 | Filtered levels of the maskable pins |
| irq_req | output | 8 | Detected requests of the maskable pins |
| nmi_level | output | 1 | Filtered level of the non-maskable pin |
| nmi_req | output | 1 | Detected request of the non-maskable pin |

## Verification
Short pulses are driven at each sampling rate: two-sample pulses must vanish and longer pulses must pass, which separates a correct three-sample window from a two-sample or four-sample one and a wrong rate ratio from the right one. A single-clock pulse on a pin with its filter off shows the fixed three-clock latency of the bypass path. Toggling enables and rate codes while inputs sit at a non-idle level exposes any false edge on reload. A long random phase gives every pin its own hold times, modes and reconfigurations, so a mixed-up pin index or mode decode shows up against the per-clock model.

// File: rtl/eint_pkg.sv
package eint_pkg;

  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_FALL = 2'b01,
    DET_RISE = 2'b10,
    DET_BOTH = 2'b11
  } det_mode_e;

  localparam logic [1:0] NMI_MODE_RISE = 2'b10;
  localparam logic [1:0] NMI_MODE_FALL = 2'b01;

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{IDLE}};
    end else begin
      chain <= {chain[STAGES-2:0], din};
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/eint_prescale.sv
module eint_prescale #(
  parameter int DIV_B = 8,
  parameter int DIV_C = 32,
  parameter int DIV_D = 64,
  localparam int CW   = (DIV_D > 2) ? $clog2(DIV_D) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [1:0]    sel_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          restart;

  always_comb begin
    unique case (sel)
      2'b00:   lim = '0;
      2'b01:   lim = CW'(DIV_B - 1);
      2'b10:   lim = CW'(DIV_C - 1);
      default: lim = CW'(DIV_D - 1);
    endcase
  end

  // A new enable or a new rate code starts a fresh period.
  assign restart = !run || (sel != sel_q);
  assign tick    = !restart && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 2'b00;
      cnt   <= '0;
    end else begin
      sel_q <= sel;
      if (restart || cnt == lim) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/eint_glitch_filter.sv
module eint_glitch_filter #(
  parameter int   LEN  = 3,
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic din,
  output logic dout
);

  logic [LEN-2:0] hist;
  logic [LEN-1:0] window;
  logic           agree;

  assign window = {hist, din};
  assign agree  = (&window) | ~(|window);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= {(LEN-1){IDLE}};
      dout <= IDLE;
    end else if (!en) begin
      // Bypass: history shadows the input so a later enable is seamless.
      hist <= {(LEN-1){din}};
      dout <= din;
    end else if (tick) begin
      hist <= (LEN-1)'(window);
      if (agree) begin
        dout <= din;
      end
    end
  end

endmodule

// File: rtl/eint_edge_detect.sv
module eint_edge_detect
  import eint_pkg::*;
#(
  parameter logic IDLE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic [1:0] mode,
  output logic       req
);

  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= IDLE;
    end else begin
      lvl_q <= lvl;
    end
  end

  always_comb begin
    unique case (det_mode_e'(mode))
      DET_LOW:  req = ~lvl;
      DET_FALL: req = lvl_q & ~lvl;
      DET_RISE: req = ~lvl_q & lvl;
      default:  req = lvl_q ^ lvl;
    endcase
  end

endmodule

// File: rtl/eint_pin_filter.sv
module eint_pin_filter
  import eint_pkg::*;
#(
  parameter int   N_IRQ    = 8,
  parameter int   SYNC_LEN = 2,
  parameter int   FILT_LEN = 3,
  parameter int   DIV_B    = 8,
  parameter int   DIV_C    = 32,
  parameter int   DIV_D    = 64,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_IRQ-1:0]   irq_pin,
  input  logic [N_IRQ-1:0]   irq_flt_en,
  input  logic [2*N_IRQ-1:0] irq_clk_sel,
  input  logic [2*N_IRQ-1:0] irq_mode,
  input  logic               nmi_pin,
  input  logic               nmi_flt_en,
  input  logic [1:0]         nmi_clk_sel,
  input  logic               nmi_rise_sense,
  output logic [N_IRQ-1:0]   irq_level,
  output logic [N_IRQ-1:0]   irq_req,
  output logic               nmi_level,
  output logic               nmi_req
);

  localparam int NCH = N_IRQ + 1;

  logic [NCH-1:0]   pin_v;
  logic [NCH-1:0]   en_v;
  logic [2*NCH-1:0] sel_v;
  logic [2*NCH-1:0] mode_v;
  logic [NCH-1:0]   sync_lv;
  logic [NCH-1:0]   tick_v;
  logic [NCH-1:0]   lvl_v;
  logic [NCH-1:0]   req_v;

  // Channel N_IRQ is the non-maskable pin; it reuses the edge modes.
  assign pin_v  = {nmi_pin, irq_pin};
  assign en_v   = {nmi_flt_en, irq_flt_en};
  assign sel_v  = {nmi_clk_sel, irq_clk_sel};
  assign mode_v = {(nmi_rise_sense ? NMI_MODE_RISE : NMI_MODE_FALL), irq_mode};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    eint_sync #(
      .STAGES (SYNC_LEN),
      .IDLE   (IDLE_LVL)
    ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_v[ch]),
      .dout  (sync_lv[ch])
    );

    eint_prescale #(
      .DIV_B (DIV_B),
      .DIV_C (DIV_C),
      .DIV_D (DIV_D)
    ) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (en_v[ch]),
      .sel   (sel_v[2*ch +: 2]),
      .tick  (tick_v[ch])
    );

    eint_glitch_filter #(
      .LEN  (FILT_LEN),
      .IDLE (IDLE_LVL)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_v[ch]),
      .tick  (tick_v[ch]),
      .din   (sync_lv[ch]),
      .dout  (lvl_v[ch])
    );

    eint_edge_detect #(
      .IDLE (IDLE_LVL)
    ) u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl_v[ch]),
      .mode  (mode_v[2*ch +: 2]),
      .req   (req_v[ch])
    );
  end

  assign irq_level = lvl_v[N_IRQ-1:0];
  assign irq_req   = req_v[N_IRQ-1:0];
  assign nmi_level = lvl_v[N_IRQ];
  assign nmi_req   = req_v[N_IRQ];

endmodule

// File: rtl/eint_pin_filter_chk.sv
module eint_pin_filter_chk #(
  parameter int NCH = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   en,
  input logic [NCH-1:0]   sync_lv,
  input logic [NCH-1:0]   tick,
  input logic [NCH-1:0]   filt,
  input logic [NCH-1:0]   req,
  input logic [2*NCH-1:0] mode
);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_no_tick_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |-> !tick[i]);

    assert_change_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en[i]) && (filt[i] != $past(filt[i]))) |-> $past(tick[i]));

    assert_change_to_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (filt[i] != $past(filt[i])) |-> (filt[i] == $past(sync_lv[i])));

    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en[i]) |-> (filt[i] == $past(sync_lv[i])));

    assert_level_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2*i +: 2] == 2'b00) |-> (req[i] == !filt[i]));

    assert_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2*i +: 2] == 2'b01) |-> (req[i] == ($past(filt[i]) && !filt[i])));

    assert_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2*i +: 2] == 2'b10) |-> (req[i] == (!$past(filt[i]) && filt[i])));

    assert_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2*i +: 2] == 2'b11) |-> (req[i] == (filt[i] != $past(filt[i]))));
  end

endmodule

bind eint_pin_filter eint_pin_filter_chk #(
  .NCH (N_IRQ + 1)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en_v),
  .sync_lv (sync_lv),
  .tick    (tick_v),
  .filt    (lvl_v),
  .req     (req_v),
  .mode    (mode_v)
);

// File: tb/sim_eint_pin_filter.sv
`timescale 1ns/1ps
module sim_eint_pin_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_pin = 8'hFF;
  logic [7:0]  irq_flt_en = 8'h00;
  logic [15:0] irq_clk_sel = 16'h0000;
  logic [15:0] irq_mode = 16'h5555;
  logic        nmi_pin = 1'b1;
  logic        nmi_flt_en = 1'b0;
  logic [1:0]  nmi_clk_sel = 2'b00;
  logic        nmi_rise_sense = 1'b0;
  logic [7:0]  irq_level;
  logic [7:0]  irq_req;
  logic        nmi_level;
  logic        nmi_req;

  always #10 clk = ~clk;

  eint_pin_filter u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .irq_pin        (irq_pin),
    .irq_flt_en     (irq_flt_en),
    .irq_clk_sel    (irq_clk_sel),
    .irq_mode       (irq_mode),
    .nmi_pin        (nmi_pin),
    .nmi_flt_en     (nmi_flt_en),
    .nmi_clk_sel    (nmi_clk_sel),
    .nmi_rise_sense (nmi_rise_sense),
    .irq_level      (irq_level),
    .irq_req        (irq_req),
    .nmi_level      (nmi_level),
    .nmi_req        (nmi_req)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // Behavioural reference: per-pin delay line, period counter and run length.
  bit m_s1 [9];
  bit m_s2 [9];
  int m_cnt [9];
  int m_selp [9];
  bit m_last [9];
  int m_run [9];
  bit m_out [9];
  bit m_fp [9];

  function automatic bit f_pin(int c);
    return (c == 8) ? nmi_pin : irq_pin[c];
  endfunction
  function automatic bit f_en(int c);
    return (c == 8) ? nmi_flt_en : irq_flt_en[c];
  endfunction
  function automatic int f_sel(int c);
    return (c == 8) ? int'(nmi_clk_sel) : int'(irq_clk_sel[2*c +: 2]);
  endfunction
  function automatic int f_mode(int c);
    if (c == 8) return nmi_rise_sense ? 2 : 1;
    return int'(irq_mode[2*c +: 2]);
  endfunction
  function automatic int f_period(int s);
    case (s)
      0: return 1;
      1: return 8;
      2: return 32;
      default: return 64;
    endcase
  endfunction
  function automatic bit f_req(int c);
    case (f_mode(c))
      0: return !m_out[c];
      1: return m_fp[c] && !m_out[c];
      2: return !m_fp[c] && m_out[c];
      default: return m_fp[c] != m_out[c];
    endcase
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < 9; c++) begin
      if (!rst_n) begin
        m_s1[c] = 1; m_s2[c] = 1; m_cnt[c] = 0; m_selp[c] = 0;
        m_last[c] = 1; m_run[c] = 3; m_out[c] = 1; m_fp[c] = 1;
      end else begin
        bit s;
        bit restart;
        bit tk;
        s = m_s2[c];
        restart = !f_en(c) || (f_sel(c) != m_selp[c]);
        tk = !restart && (m_cnt[c] == f_period(f_sel(c)) - 1);
        m_fp[c] = m_out[c];
        if (!f_en(c)) begin
          m_last[c] = s; m_run[c] = 3; m_out[c] = s;
        end else if (tk) begin
          if (s == m_last[c]) m_run[c]++;
          else begin m_last[c] = s; m_run[c] = 1; end
          if (m_run[c] >= 3) m_out[c] = s;
        end
        if (restart || tk) m_cnt[c] = 0;
        else m_cnt[c]++;
        m_selp[c] = f_sel(c);
        m_s2[c] = m_s1[c];
        m_s1[c] = f_pin(c);
      end
    end
  end

  task automatic chk(string tag, bit act, bit exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
    if (rst_n) begin
      for (int c = 0; c < 9; c++) begin
        bit al;
        bit ar;
        string lt;
        string rt;
        al = (c == 8) ? nmi_level : irq_level[c];
        ar = (c == 8) ? nmi_req : irq_req[c];
        lt = !f_en(c) ? "R2" : (f_sel(c) != 0 ? "R4" : "R3");
        case (f_mode(c))
          0: rt = "R6";
          1: rt = "R7";
          2: rt = "R8";
          default: rt = "R9";
        endcase
        if (c == 8) rt = "R10";
        chk(lt, al, m_out[c], $sformatf("level pin %0d", c));
        chk(rt, ar, f_req(c), $sformatf("request pin %0d", c));
      end
    end
  end

  task automatic drive_wait(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  initial begin
    drive_wait(4);
    rst_n = 1'b1;
    drive_wait(3);
    // R1: idle after reset
    chk("R1", irq_level == 8'hFF, 1'b1, "levels after reset");
    chk("R1", irq_req == 8'h00, 1'b1, "requests after reset");
    chk("R1", nmi_level, 1'b1, "nmi level after reset");

    // R2: bypass, single-clock low pulse on pin 3 appears 3 clocks later
    irq_pin[3] = 1'b0;
    drive_wait(1);
    irq_pin[3] = 1'b1;
    drive_wait(1);
    chk("R2", irq_level[3], 1'b1, "bypass before latency");
    @(negedge clk);
    chk("R2", irq_level[3], 1'b0, "bypass after three clocks");
    drive_wait(5);

    // R3: pin 0 filtered at full rate, falling edge mode
    irq_flt_en[0] = 1'b1;
    drive_wait(4);
    irq_pin[0] = 1'b0;
    drive_wait(2);
    irq_pin[0] = 1'b1;
    drive_wait(8);
    chk("R3", irq_level[0], 1'b1, "two-sample pulse removed");
    irq_pin[0] = 1'b0;
    drive_wait(10);
    chk("R3", irq_level[0], 1'b0, "long pulse passed");
    irq_pin[0] = 1'b1;
    drive_wait(10);

    // R4: slower rates reject pulses spanning at most two samples
    irq_flt_en[1] = 1'b1; irq_clk_sel[3:2] = 2'b01;
    irq_flt_en[2] = 1'b1; irq_clk_sel[5:4] = 2'b10;
    irq_flt_en[4] = 1'b1; irq_clk_sel[9:8] = 2'b11;
    drive_wait(70);
    irq_pin[1] = 1'b0; irq_pin[2] = 1'b0; irq_pin[4] = 1'b0;
    drive_wait(10);
    irq_pin[1] = 1'b1;
    drive_wait(50);
    irq_pin[2] = 1'b1;
    drive_wait(60);
    irq_pin[4] = 1'b1;
    drive_wait(200);
    chk("R4", irq_level[1], 1'b1, "rate 8 short pulse removed");
    chk("R4", irq_level[2], 1'b1, "rate 32 short pulse removed");
    chk("R4", irq_level[4], 1'b1, "rate 64 short pulse removed");
    irq_pin[4] = 1'b0;
    drive_wait(300);
    chk("R4", irq_level[4], 1'b0, "rate 64 long pulse passed");
    irq_pin[4] = 1'b1;
    drive_wait(300);

    // R5: enabling on a non-idle input, both-edge mode, no request
    irq_mode[11:10] = 2'b11;
    irq_pin[5] = 1'b0;
    drive_wait(6);
    irq_flt_en[5] = 1'b1; irq_clk_sel[11:10] = 2'b10;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk("R5", irq_req[5], 1'b0, "no request on enable");
      chk("R5", irq_level[5], 1'b0, "level kept on enable");
    end
    irq_clk_sel[11:10] = 2'b00;
    drive_wait(10);
    chk("R5", irq_level[5], 1'b0, "level kept on rate change");

    // R10: non-maskable pin, rising sense, filtered at full rate
    nmi_rise_sense = 1'b1; nmi_flt_en = 1'b1;
    nmi_pin = 1'b0;
    drive_wait(12);
    nmi_pin = 1'b1;
    drive_wait(12);
    chk("R10", nmi_level, 1'b1, "nmi back high");

    // R11: every pin random and independent, occasional reconfiguration
    for (int t = 0; t < 6000; t++) begin
      for (int c = 0; c < 9; c++) begin
        if ($urandom_range(0, 40) == 0) begin
          if (c == 8) nmi_pin = ~nmi_pin;
          else irq_pin[c] = ~irq_pin[c];
        end
        if ($urandom_range(0, 3) == 0 && $urandom_range(0, 1) == 0 && c < 8)
          irq_pin[c] = ~irq_pin[c];
      end
      if ($urandom_range(0, 250) == 0) begin
        int c;
        c = $urandom_range(0, 8);
        if (c == 8) begin
          nmi_flt_en = 1'($urandom_range(0, 1));
          nmi_clk_sel = 2'($urandom_range(0, 3));
          nmi_rise_sense = 1'($urandom_range(0, 1));
        end else begin
          irq_flt_en[c] = 1'($urandom_range(0, 3) != 0);
          irq_clk_sel[2*c +: 2] = 2'($urandom_range(0, 3));
          irq_mode[2*c +: 2] = 2'($urandom_range(0, 3));
        end
      end
      drive_wait(1);
    end
    drive_wait(5);
    report();
  end

endmodule